// File: doc/BRIEF.md
# Interrupt Context Save/Restore Unit

This unit is the interrupt entry and return logic of a small 8-bit processor core. It watches eight external edge sources and the overflow of the real-time counter it owns. When a request is accepted, it does four things in one clock edge. It pushes the current program counter onto a one-deep stack of its own, which is kept apart from the subroutine stack. It copies the working register, the status register and the file-select register into shadow registers. It clears the global interrupt enable. It then directs the core to load the program counter with the vector address 0 and a status value whose page-select field (bits 7:5) is cleared.

On a return command, the unit hands the saved program counter and the three shadow values back to the core and re-enables interrupts. The return-with-add variant also adds the core's current working register to the real-time counter. Interrupts do not nest and no source has priority. While a service routine runs, external edges still latch into the pending register, but they never start a new entry. Software clears pending bits through a clear mask. An overflow of the counter has no pending bit.

The core's live registers and program counter enter as plain ports. All results leave as registered load strobes with their values, one cycle after the cycle that caused them. A value output holds its last value while its strobe is low.

Top module: `irq_ctx_unit`

## Requirements
- R1: After reset the global enable is 1, the pending register is 0x00, the counter is 0x00, and every load strobe and `irqTake` are 0.
- R2: A request is accepted in a cycle where the global enable is 1 and some `extEdge` bit is 1 whose `extEnable` bit is 1 and whose pending bit was 0 before that cycle. In the next cycle `irqTake`, `pcLoad` and `statusLoad` are 1, `pcLoadVal` is 0, and the global enable is 0.
- R3: Every cycle, the pending register becomes (old & ~`pendClr`) | `extEdge`. This holds whatever the state of the global enable and the enables; a set wins over a clear on the same bit.
- R4: No entry starts from an edge on a bit whose pending bit is already 1, from an edge on a bit whose enable is 0, or from any source while the global enable is 0.
- R5: The counter increments by one on each `rtccTick`. A tick taken at 0xFF rolls it to 0x00 and, when `rtccIntEn` is 1 and the global enable is 1, causes an entry exactly as in R2. The rollover sets no pending bit.
- R6: On entry, the stack and the shadows capture `curPc`, `coreW`, `coreStatus` and `coreFsr` from the accepting cycle. `statusLoadVal` equals that status with bits 7:5 forced to 0, and `wLoad` and `fsrLoad` stay 0.
- R7: `retiCmd` or `retiwCmd` while the global enable is 0 gives, in the next cycle, `pcLoad`, `wLoad`, `statusLoad` and `fsrLoad` all at 1, carrying the stacked PC and the unmodified shadow values, and sets the global enable to 1. A return command while the global enable is 1 is ignored.
- R8: An accepted `retiwCmd` also adds `coreW` of that cycle to the counter, on top of any tick in the same cycle, modulo 256.
- R9: Simultaneous requests give a single one-cycle `irqTake` pulse. The shadows and stack do not change until the next return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| extEdge | input | 8 | One-cycle edge events from external sources |
| extEnable | input | 8 | Per-source interrupt enable |
| pendClr | input | 8 | Mask of pending bits to clear |
| rtccTick | input | 1 | Counter increment pulse |
| rtccIntEn | input | 1 | Counter rollover interrupt enable |
| curPc | input | 11 | Core program counter of this cycle |
| coreW | input | 8 | Core working register |
| coreStatus | input | 8 | Core status register |
| coreFsr | input | 8 | Core file-select register |
| retiCmd | input | 1 | Return-from-interrupt command |
| retiwCmd | input | 1 | Return command that also adds W to the counter |
| irqTake | output | 1 | Entry pulse |
| gieOut | output | 1 | Global interrupt enable |
| pendOut | output | 8 | Pending register |
| rtccOut | output | 8 | Real-time counter |
| pcLoad | output | 1 | PC load strobe |
| pcLoadVal | output | 11 | PC value to load |
| wLoad | output | 1 | W restore strobe |
| wLoadVal | output | 8 | W restore value |
| statusLoad | output | 1 | Status load strobe |
| statusLoadVal | output | 8 | Status value to load |
| fsrLoad | output | 1 | FSR restore strobe |
| fsrLoadVal | output | 8 | FSR restore value |

## Verification
Every result of this unit passes through exactly one register. The entry pulse, the load strobes and values, the enable flag, the pending bits and the counter are all due in the first cycle after the cycle whose inputs caused them. The bench therefore drives inputs on the falling edge and advances a behavioural model over the same edge. It compares every output on the next falling edge, so each comparison lands on the cycle in which the result is due. Directed checks read the ports at that same sampling point. These checks cover a return in both enable states, blocked triggers, rollover and the add on return.

// File: rtl/irq_ctx_pkg.sv
package irq_ctx_pkg;
  // Strobes passed from control to datapath for one cycle
  typedef struct packed {
    logic take;   // accept an interrupt this cycle
    logic ret;    // accept a return this cycle
    logic addW;   // return also adds W to the counter
  } ctxStrobe_t;
endpackage

// File: rtl/irq_ctx_ctrl.sv
module irq_ctx_ctrl
  import irq_ctx_pkg::*;
#(
  parameter int SRC_N  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  extEdge,
  input  logic [SRC_N-1:0]  extEnable,
  input  logic [SRC_N-1:0]  pendQ,
  input  logic [DATA_W-1:0] rtccQ,
  input  logic              rtccTick,
  input  logic              rtccIntEn,
  input  logic              retiCmd,
  input  logic              retiwCmd,
  output ctxStrobe_t        strobe,
  output logic              gie
);
  localparam logic [DATA_W-1:0] RTCC_TOP = '1;

  logic [SRC_N-1:0] srcReq;
  logic             extReq;
  logic             rtccReq;
  logic             anyRet;

  // Per-source request: a fresh edge on an enabled, not yet pending bit
  for (genvar i = 0; i < SRC_N; i++) begin : g_src
    assign srcReq[i] = extEdge[i] & extEnable[i] & ~pendQ[i];
  end

  assign extReq  = |srcReq;
  assign rtccReq = rtccTick & rtccIntEn & (rtccQ == RTCC_TOP);
  assign anyRet  = retiCmd | retiwCmd;

  always_comb begin
    strobe      = '0;
    strobe.take = gie & (extReq | rtccReq);
    strobe.ret  = ~gie & anyRet;
    strobe.addW = ~gie & retiwCmd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie <= 1'b1;
    end else if (strobe.take) begin
      gie <= 1'b0;
    end else if (strobe.ret) begin
      gie <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_ctx_dp.sv
module irq_ctx_dp
  import irq_ctx_pkg::*;
#(
  parameter int               SRC_N   = 8,
  parameter int               DATA_W  = 8,
  parameter int               PC_W    = 11,
  parameter int               PAGE_HI = 7,
  parameter int               PAGE_LO = 5,
  parameter logic [PC_W-1:0]  VECTOR  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctxStrobe_t        strobe,
  input  logic [SRC_N-1:0]  extEdge,
  input  logic [SRC_N-1:0]  pendClr,
  input  logic              rtccTick,
  input  logic [PC_W-1:0]   curPc,
  input  logic [DATA_W-1:0] coreW,
  input  logic [DATA_W-1:0] coreStatus,
  input  logic [DATA_W-1:0] coreFsr,
  output logic [SRC_N-1:0]  pendQ,
  output logic [DATA_W-1:0] rtccQ,
  output logic              irqTake,
  output logic              pcLoad,
  output logic [PC_W-1:0]   pcLoadVal,
  output logic              wLoad,
  output logic [DATA_W-1:0] wLoadVal,
  output logic              statusLoad,
  output logic [DATA_W-1:0] statusLoadVal,
  output logic              fsrLoad,
  output logic [DATA_W-1:0] fsrLoadVal
);
  localparam int PAGE_N = PAGE_HI - PAGE_LO + 1;

  logic [PC_W-1:0]   pcStack;
  logic [DATA_W-1:0] shadowW;
  logic [DATA_W-1:0] shadowStatus;
  logic [DATA_W-1:0] shadowFsr;
  logic [DATA_W-1:0] statusMasked;
  logic [DATA_W-1:0] rtccAdd;

  // Page-select field cleared in the value sent to the core
  always_comb begin
    statusMasked = coreStatus;
    statusMasked[PAGE_HI:PAGE_LO] = {PAGE_N{1'b0}};
  end

  assign rtccAdd = (strobe.addW ? coreW : '0) + DATA_W'(rtccTick);

  // Pending register: set wins over clear
  always_ff @(posedge clk) begin
    if (!rst_n) pendQ <= '0;
    else        pendQ <= (pendQ & ~pendClr) | extEdge;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rtccQ <= '0;
    else        rtccQ <= rtccQ + rtccAdd;
  end

  // One-deep stack and shadows, written only on entry
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcStack      <= '0;
      shadowW      <= '0;
      shadowStatus <= '0;
      shadowFsr    <= '0;
    end else if (strobe.take) begin
      pcStack      <= curPc;
      shadowW      <= coreW;
      shadowStatus <= coreStatus;
      shadowFsr    <= coreFsr;
    end
  end

  // Registered load strobes toward the core
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irqTake    <= 1'b0;
      pcLoad     <= 1'b0;
      wLoad      <= 1'b0;
      statusLoad <= 1'b0;
      fsrLoad    <= 1'b0;
    end else begin
      irqTake    <= strobe.take;
      pcLoad     <= strobe.take | strobe.ret;
      statusLoad <= strobe.take | strobe.ret;
      wLoad      <= strobe.ret;
      fsrLoad    <= strobe.ret;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcLoadVal     <= '0;
      wLoadVal      <= '0;
      statusLoadVal <= '0;
      fsrLoadVal    <= '0;
    end else if (strobe.take) begin
      pcLoadVal     <= VECTOR;
      statusLoadVal <= statusMasked;
    end else if (strobe.ret) begin
      pcLoadVal     <= pcStack;
      wLoadVal      <= shadowW;
      statusLoadVal <= shadowStatus;
      fsrLoadVal    <= shadowFsr;
    end
  end
endmodule

// File: rtl/irq_ctx_unit.sv
module irq_ctx_unit
  import irq_ctx_pkg::*;
#(
  parameter int SRC_N   = 8,
  parameter int DATA_W  = 8,
  parameter int PC_W    = 11,
  parameter int PAGE_HI = 7,
  parameter int PAGE_LO = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  extEdge,
  input  logic [SRC_N-1:0]  extEnable,
  input  logic [SRC_N-1:0]  pendClr,
  input  logic              rtccTick,
  input  logic              rtccIntEn,
  input  logic [PC_W-1:0]   curPc,
  input  logic [DATA_W-1:0] coreW,
  input  logic [DATA_W-1:0] coreStatus,
  input  logic [DATA_W-1:0] coreFsr,
  input  logic              retiCmd,
  input  logic              retiwCmd,
  output logic              irqTake,
  output logic              gieOut,
  output logic [SRC_N-1:0]  pendOut,
  output logic [DATA_W-1:0] rtccOut,
  output logic              pcLoad,
  output logic [PC_W-1:0]   pcLoadVal,
  output logic              wLoad,
  output logic [DATA_W-1:0] wLoadVal,
  output logic              statusLoad,
  output logic [DATA_W-1:0] statusLoadVal,
  output logic              fsrLoad,
  output logic [DATA_W-1:0] fsrLoadVal
);
  ctxStrobe_t strobe;

  irq_ctx_ctrl #(.SRC_N(SRC_N), .DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .extEdge(extEdge), .extEnable(extEnable),
    .pendQ(pendOut), .rtccQ(rtccOut), .rtccTick(rtccTick),
    .rtccIntEn(rtccIntEn), .retiCmd(retiCmd), .retiwCmd(retiwCmd),
    .strobe(strobe), .gie(gieOut)
  );

  irq_ctx_dp #(
    .SRC_N(SRC_N), .DATA_W(DATA_W), .PC_W(PC_W),
    .PAGE_HI(PAGE_HI), .PAGE_LO(PAGE_LO), .VECTOR('0)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .extEdge(extEdge),
    .pendClr(pendClr), .rtccTick(rtccTick), .curPc(curPc), .coreW(coreW),
    .coreStatus(coreStatus), .coreFsr(coreFsr), .pendQ(pendOut),
    .rtccQ(rtccOut), .irqTake(irqTake), .pcLoad(pcLoad),
    .pcLoadVal(pcLoadVal), .wLoad(wLoad), .wLoadVal(wLoadVal),
    .statusLoad(statusLoad), .statusLoadVal(statusLoadVal),
    .fsrLoad(fsrLoad), .fsrLoadVal(fsrLoadVal)
  );
endmodule

// File: rtl/irq_ctx_chk.sv
module irq_ctx_chk #(
  parameter int SRC_N   = 8,
  parameter int DATA_W  = 8,
  parameter int PC_W    = 11,
  parameter int PAGE_HI = 7,
  parameter int PAGE_LO = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SRC_N-1:0]  extEdge,
  input logic              retiCmd,
  input logic              retiwCmd,
  input logic              irqTake,
  input logic              gieOut,
  input logic [SRC_N-1:0]  pendOut,
  input logic              pcLoad,
  input logic [PC_W-1:0]   pcLoadVal,
  input logic              wLoad,
  input logic              statusLoad,
  input logic [DATA_W-1:0] statusLoadVal,
  input logic              fsrLoad
);
  AST_TAKE_CLEARS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    irqTake |-> !gieOut);  // R2
  AST_TAKE_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    irqTake |-> (pcLoad && pcLoadVal == '0));  // R2
  AST_PEND_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (|extEdge) |=> ((pendOut & $past(extEdge)) == $past(extEdge)));  // R3
  AST_NO_NEST: assert property (@(posedge clk) disable iff (!rst_n)
    !gieOut |=> !irqTake);  // R4
  AST_PAGE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    irqTake |-> (statusLoad && statusLoadVal[PAGE_HI:PAGE_LO] == '0));  // R6
  AST_ENTRY_NO_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    irqTake |-> (!wLoad && !fsrLoad));  // R6
  AST_RETURN_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    ((retiCmd || retiwCmd) && !gieOut) |=> (gieOut && pcLoad && wLoad && statusLoad && fsrLoad));  // R7
  AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irqTake |=> !irqTake);  // R9
endmodule

bind irq_ctx_unit irq_ctx_chk #(
  .SRC_N(SRC_N), .DATA_W(DATA_W), .PC_W(PC_W),
  .PAGE_HI(PAGE_HI), .PAGE_LO(PAGE_LO)
) chk_i (
  .clk(clk), .rst_n(rst_n), .extEdge(extEdge), .retiCmd(retiCmd),
  .retiwCmd(retiwCmd), .irqTake(irqTake), .gieOut(gieOut),
  .pendOut(pendOut), .pcLoad(pcLoad), .pcLoadVal(pcLoadVal),
  .wLoad(wLoad), .statusLoad(statusLoad), .statusLoadVal(statusLoadVal),
  .fsrLoad(fsrLoad)
);

// File: tb/irq_ctx_unit_tb.sv
module irq_ctx_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  extEdge, extEnable, pendClr;
  logic        rtccTick, rtccIntEn;
  logic [10:0] curPc;
  logic [7:0]  coreW, coreStatus, coreFsr;
  logic        retiCmd, retiwCmd;
  logic        irqTake, gieOut, pcLoad, wLoad, statusLoad, fsrLoad;
  logic [7:0]  pendOut, rtccOut, wLoadVal, statusLoadVal, fsrLoadVal;
  logic [10:0] pcLoadVal;

  always #5ns clk = ~clk;

  irq_ctx_unit dut_i (
    .clk(clk), .rst_n(rst_n), .extEdge(extEdge), .extEnable(extEnable),
    .pendClr(pendClr), .rtccTick(rtccTick), .rtccIntEn(rtccIntEn),
    .curPc(curPc), .coreW(coreW), .coreStatus(coreStatus), .coreFsr(coreFsr),
    .retiCmd(retiCmd), .retiwCmd(retiwCmd), .irqTake(irqTake),
    .gieOut(gieOut), .pendOut(pendOut), .rtccOut(rtccOut), .pcLoad(pcLoad),
    .pcLoadVal(pcLoadVal), .wLoad(wLoad), .wLoadVal(wLoadVal),
    .statusLoad(statusLoad), .statusLoadVal(statusLoadVal),
    .fsrLoad(fsrLoad), .fsrLoadVal(fsrLoadVal)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Behavioural reference state
  int mGie, mPend, mRtcc, mStk, mShW, mShS, mShF;
  int eTake, ePcL, ePcV, eWL, eWV, eSL, eSV, eFL, eFV;

  task automatic cmp(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mGie = 1; mPend = 0; mRtcc = 0; mStk = 0; mShW = 0; mShS = 0; mShF = 0;
    eTake = 0; ePcL = 0; ePcV = 0; eWL = 0; eWV = 0; eSL = 0; eSV = 0;
    eFL = 0; eFV = 0;
  endtask

  task automatic idleInputs();
    extEdge = 0; pendClr = 0; rtccTick = 0; retiCmd = 0; retiwCmd = 0;
  endtask

  // Advance the model over one edge from the current inputs
  task automatic modelStep();
    int take, ret, addv;
    take = mGie && (((extEdge & extEnable & ~mPend[7:0]) != 0) ||
                    (rtccTick && rtccIntEn && mRtcc == 255));
    ret  = !mGie && (retiCmd || retiwCmd);
    addv = (ret && retiwCmd) ? int'(coreW) : 0;
    eTake = take;
    ePcL  = take || ret;
    eSL   = take || ret;
    eWL   = ret;
    eFL   = ret;
    if (take) begin
      ePcV = 0; eSV = coreStatus & 8'h1F;
      mStk = curPc; mShW = coreW; mShS = coreStatus; mShF = coreFsr;
      mGie = 0;
    end else if (ret) begin
      ePcV = mStk; eWV = mShW; eSV = mShS; eFV = mShF;
      mGie = 1;
    end
    mPend = ((mPend & ~int'(pendClr)) | int'(extEdge)) & 8'hFF;
    mRtcc = (mRtcc + int'(rtccTick) + addv) & 8'hFF;
  endtask

  task automatic compareAll();
    cmp("R2 irqTake", irqTake, eTake);
    cmp("R2 gieOut", gieOut, mGie);
    cmp("R2 pcLoad", pcLoad, ePcL);
    cmp("R7 pcLoadVal", pcLoadVal, ePcV);
    cmp("R3 pendOut", pendOut, mPend);
    cmp("R5 rtccOut", rtccOut, mRtcc);
    cmp("R6 statusLoad", statusLoad, eSL);
    cmp("R6 statusLoadVal", statusLoadVal, eSV);
    cmp("R7 wLoad", wLoad, eWL);
    cmp("R7 wLoadVal", wLoadVal, eWV);
    cmp("R7 fsrLoad", fsrLoad, eFL);
    cmp("R7 fsrLoadVal", fsrLoadVal, eFV);
  endtask

  // Inputs are set at a falling edge; results are read at the next one
  task automatic step();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    compareAll();
    idleInputs();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int savedPend;
    idleInputs();
    extEnable = 8'hFF; rtccIntEn = 0;
    curPc = 0; coreW = 0; coreStatus = 0; coreFsr = 0;
    rst_n = 0;
    modelReset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    cmp("R1 gie after reset", gieOut, 1);
    cmp("R1 pending after reset", pendOut, 0);
    cmp("R1 rtcc after reset", rtccOut, 0);
    cmp("R1 loads after reset", {irqTake, pcLoad, wLoad, statusLoad, fsrLoad}, 0);

    // R2/R6 entry on a fresh enabled edge
    curPc = 11'h2AB; coreW = 8'h11; coreStatus = 8'hE5; coreFsr = 8'h33;
    extEdge = 8'h04;
    step();
    cmp("R2 entry pulse", irqTake, 1);
    cmp("R2 vector", pcLoadVal, 0);
    cmp("R6 page bits cleared", statusLoadVal, 8'h05);
    cmp("R6 no W restore on entry", wLoad, 0);

    // R3/R4 edge during service latches but does not enter
    curPc = 11'h001; coreW = 8'h99; coreStatus = 8'h00; coreFsr = 8'h77;
    extEdge = 8'h10;
    step();
    cmp("R4 no entry in service", irqTake, 0);
    cmp("R3 pending latched in service", pendOut, 8'h14);
    step();

    // R7/R9 return gives the original context back
    retiCmd = 1;
    step();
    cmp("R7 restored PC", pcLoadVal, 11'h2AB);
    cmp("R9 shadow W unchanged", wLoadVal, 8'h11);
    cmp("R7 restored status", statusLoadVal, 8'hE5);
    cmp("R7 restored FSR", fsrLoadVal, 8'h33);
    cmp("R7 gie back", gieOut, 1);

    // R7 return while enabled is ignored
    retiCmd = 1;
    step();
    cmp("R7 ignored return", {pcLoad, wLoad, fsrLoad}, 0);

    // R4 edge on already pending bit, then on disabled bit
    extEdge = 8'h04;
    step();
    cmp("R4 pending bit blocks entry", irqTake, 0);
    extEnable = 8'hFE; extEdge = 8'h01;
    step();
    cmp("R4 disabled source", irqTake, 0);
    cmp("R3 disabled source still pends", pendOut, 8'h15);
    extEnable = 8'hFF;

    // R3 set wins over clear on same bit; clear others
    pendClr = 8'hFF; extEdge = 8'h04;
    step();
    cmp("R3 set wins clear", pendOut, 8'h04);
    pendClr = 8'h04;
    step();
    cmp("R3 clear", pendOut, 8'h00);

    // R5 rollover entry, no pending bit
    rtccIntEn = 1;
    for (int i = 0; i < 255; i++) begin
      rtccTick = 1;
      step();
    end
    cmp("R5 counter at top", rtccOut, 255);
    cmp("R5 no entry before rollover", irqTake, 0);
    savedPend = pendOut;
    rtccTick = 1;
    step();
    cmp("R5 rollover entry", irqTake, 1);
    cmp("R5 counter wrapped", rtccOut, 0);
    cmp("R5 no pending bit", pendOut, savedPend);

    // R8 return with add
    coreW = 8'h10; retiwCmd = 1; rtccTick = 1;
    step();
    cmp("R8 counter plus W and tick", rtccOut, 8'h11);
    cmp("R8 gie back", gieOut, 1);

    // R9 simultaneous sources give one pulse
    rtccIntEn = 0;
    extEdge = 8'hC0;
    step();
    cmp("R9 single entry", irqTake, 1);
    step();
    cmp("R9 pulse ends", irqTake, 0);
    retiCmd = 1;
    step();

    // Mixed random traffic against the model
    for (int i = 0; i < 400; i++) begin
      extEdge    = ($urandom % 6 == 0) ? 8'($urandom) : 8'h00;
      pendClr    = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
      extEnable  = 8'($urandom);
      rtccTick   = 1'($urandom);
      rtccIntEn  = 1'($urandom);
      retiCmd    = ($urandom % 8 == 0);
      retiwCmd   = ($urandom % 10 == 0);
      curPc      = 11'($urandom);
      coreW      = 8'($urandom);
      coreStatus = 8'($urandom);
      coreFsr    = 8'($urandom);
      step();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule